// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block steers instruction fetch for a small accumulator-based controller whose instructions are 12 bits wide. It owns the program counter, a shallow hardware return stack that software cannot reach, and the logic that builds jump targets from a short address field plus page bits taken from the status register. The default configuration gives an 11-bit fetch address: four pages of 512 words, 2048 words in all.

The instruction decoder drives one decoded control strobe per cycle for the instruction now executing. The choices are an absolute jump, a subroutine call, a return that also loads a literal, a write to the low counter byte, or a conditional skip that fired. The block answers with the fetch address and a combinational `flush` that marks the instruction fetched in this cycle as a no-op.

The instruction marked by `flush` reaches execute in the next cycle. Its strobes are ignored there. This gives every taken transfer and every fired skip a one-cycle penalty, and it lets a skip discard a following skip.

Top module: `pcs_seq`

## Requirements
- R1: While reset is applied, and in the first cycles after its release, the fetch address is 0x1FF and `flush` is low, whatever the control strobes are.
- R2: In a cycle with no strobe, or with its strobes ignored, the fetch address of the next cycle is the current one plus one, wrapping from the top of the full space to 0.
- R3: A jump makes the next fetch address {page_sel, addr_field[8:0]}, and `flush` is high in the jump cycle.
- R4: A call makes the next fetch address {page_sel, 0, addr_field[7:0]}. Bit 8 of the target is always 0, whatever addr_field[8] holds. The call pushes the current fetch address, which is the word after the call, and raises `flush`.
- R5: A return makes the next fetch address the most recently pushed entry, pops the stack and raises `flush`. Returns come back in last-in-first-out order over two nesting levels.
- R6: The stack holds two entries. A third nested call drops the oldest entry. A return with fewer live entries than returns keeps returning the deepest remaining entry.
- R7: A write to the low counter byte makes the next fetch address {page_sel, 0, pcl_value} and raises `flush`.
- R8: A fired skip raises `flush` and lets the fetch address advance by one. As a result, the instruction after the skip is discarded and the one after that executes.
- R9: In the cycle after `flush` was high, all strobes are ignored: `flush` stays low and the address advances by one. A skip that lands on a skip therefore discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| op_jump | input | 1 | Executing instruction is an absolute jump |
| op_call | input | 1 | Executing instruction is a subroutine call |
| op_ret | input | 1 | Executing instruction is a return that loads a literal |
| op_pcl_wr | input | 1 | Executing instruction writes the low counter byte |
| op_skip | input | 1 | Executing instruction is a skip whose condition is true |
| addr_field | input | 9 | Address field of a jump or call |
| pcl_value | input | 8 | Byte written to the low counter byte |
| page_sel | input | PAGE_W | Page-select bits from the status register |
| fetch_addr | output | 9+PAGE_W | Program memory address fetched this cycle |
| flush | output | 1 | The instruction fetched this cycle is to be executed as a no-op |

## Verification
The assertions assume that the decoder raises at most one strobe per cycle. They also assume that `page_sel`, `addr_field` and `pcl_value` are stable from one falling edge to the next rising edge. The stimulus table holds exactly one strobe, or none, in each row, and it changes inputs only on the falling edge. In rows whose instruction has been squashed, the table still drives a strobe, to show that the strobe is ignored. The only cycle with a call strobe held during reset is a directed case, and the strobe is cleared before the synchronized reset releases.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Source of the next fetch address
  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_JUMP = 3'd1,
    SEL_CALL = 3'd2,
    SEL_RET  = 3'd3,
    SEL_PCL  = 3'd4
  } next_sel_e;

  localparam int PAGE_OFS_W = 9;  // words addressed inside one page
  localparam int LOW_BYTE_W = 8;  // call field and computed-jump byte

endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q = chain_q[STAGES-1];

endmodule

// File: rtl/pcs_target_gen.sv
module pcs_target_gen
  import pcs_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int ADDR_W = PAGE_OFS_W + PAGE_W
) (
  input  next_sel_e               sel,
  input  logic [PAGE_W-1:0]       page_sel,
  input  logic [PAGE_OFS_W-1:0]   addr_field,
  input  logic [LOW_BYTE_W-1:0]   pcl_value,
  output logic [ADDR_W-1:0]       target
);

  always_comb begin
    unique case (sel)
      SEL_JUMP: target = {page_sel, addr_field};
      SEL_CALL: target = {page_sel, 1'b0, addr_field[LOW_BYTE_W-1:0]};
      SEL_PCL:  target = {page_sel, 1'b0, pcl_value};
      default:  target = '0;
    endcase
  end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] top
);

  logic [ADDR_W-1:0] ent_q [DEPTH];
  logic [ADDR_W-1:0] ent_d [DEPTH];
  logic              stk_en;

  assign stk_en = push | pop;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic [ADDR_W-1:0] from_above;
    logic [ADDR_W-1:0] from_below;

    if (gi == 0) begin : g_first
      assign from_above = push_data;
    end else begin : g_inner
      assign from_above = ent_q[gi-1];
    end

    if (gi == DEPTH-1) begin : g_last
      assign from_below = ent_q[gi];      // deepest entry repeats on pop
    end else begin : g_mid
      assign from_below = ent_q[gi+1];
    end

    always_comb begin
      if (push) begin
        ent_d[gi] = from_above;
      end else if (pop) begin
        ent_d[gi] = from_below;
      end else begin
        ent_d[gi] = ent_q[gi];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[gi] <= '0;
      end else if (stk_en) begin
        ent_q[gi] <= ent_d[gi];
      end
    end
  end

  assign top = ent_q[0];

  AST_PUSH_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top == $past(push_data)));  // R4

  AST_DEEPEST_KEPT_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> $stable(ent_q[DEPTH-1]));  // R6

endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
  import pcs_pkg::*;
#(
  parameter int                       PAGE_W      = 2,
  parameter int                       STACK_DEPTH = 2,
  parameter logic [PAGE_OFS_W+PAGE_W-1:0] RESET_ADDR = 'h1FF,
  localparam int                      ADDR_W      = PAGE_OFS_W + PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_jump,
  input  logic                  op_call,
  input  logic                  op_ret,
  input  logic                  op_pcl_wr,
  input  logic                  op_skip,
  input  logic [PAGE_OFS_W-1:0] addr_field,
  input  logic [LOW_BYTE_W-1:0] pcl_value,
  input  logic [PAGE_W-1:0]     page_sel,
  output logic [ADDR_W-1:0]     fetch_addr,
  output logic                  flush
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              rst_q;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              kill_q, kill_d;
  next_sel_e         sel;
  logic              skip_live;
  logic              redirect;
  logic [ADDR_W-1:0] jump_tgt;
  logic [ADDR_W-1:0] ret_top;
  logic              push, pop;

  pcs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // Decode of the executing instruction; a squashed slot decodes as increment
  always_comb begin
    sel       = SEL_INC;
    skip_live = 1'b0;
    if (!kill_q) begin
      if (op_ret) begin
        sel = SEL_RET;
      end else if (op_call) begin
        sel = SEL_CALL;
      end else if (op_jump) begin
        sel = SEL_JUMP;
      end else if (op_pcl_wr) begin
        sel = SEL_PCL;
      end else begin
        skip_live = op_skip;
      end
    end
  end

  assign redirect = (sel != SEL_INC);
  assign push     = (sel == SEL_CALL);
  assign pop      = (sel == SEL_RET);

  pcs_target_gen #(.PAGE_W(PAGE_W)) u_target (
    .sel        (sel),
    .page_sel   (page_sel),
    .addr_field (addr_field),
    .pcl_value  (pcl_value),
    .target     (jump_tgt)
  );

  pcs_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (push),
    .pop       (pop),
    .push_data (pc_q),
    .top       (ret_top)
  );

  // Next-state
  always_comb begin
    if (pop) begin
      pc_d = ret_top;
    end else if (redirect) begin
      pc_d = jump_tgt;
    end else begin
      pc_d = pc_q + ADDR_ONE;
    end
    kill_d = redirect | skip_live;
  end

  // State
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc_q   <= RESET_ADDR;
      kill_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      kill_q <= kill_d;
    end
  end

  assign fetch_addr = pc_q;
  assign flush      = rst_q & kill_d;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({op_jump, op_call, op_ret, op_pcl_wr, op_skip}));  // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_q)
    !flush |=> (fetch_addr == $past(fetch_addr) + ADDR_ONE));  // R2

  AST_JUMP_PAGE: assert property (@(posedge clk) disable iff (!rst_q)
    (op_jump && !kill_q) |=>
      (fetch_addr == {$past(page_sel), $past(addr_field)}));  // R3

  AST_CALL_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_q)
    (op_call && !kill_q) |=> (fetch_addr[PAGE_OFS_W-1] == 1'b0));  // R4

  AST_RET_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_q)
    (op_ret && !kill_q) |=> (fetch_addr == $past(ret_top)));  // R5

  AST_PCL_BYTE: assert property (@(posedge clk) disable iff (!rst_q)
    (op_pcl_wr && !kill_q && !op_ret && !op_call && !op_jump) |=>
      (fetch_addr == {$past(page_sel), 1'b0, $past(pcl_value)}));  // R7

  AST_SKIP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_q)
    (op_skip && !kill_q) |-> flush);  // R8

  AST_NO_FLUSH_TWICE: assert property (@(posedge clk) disable iff (!rst_q)
    flush |=> !flush);  // R9

endmodule

// File: tb/test_pcs_seq.sv
module test_pcs_seq;

  logic        clk;
  logic        rst_n;
  logic        op_jump, op_call, op_ret, op_pcl_wr, op_skip;
  logic [8:0]  addr_field;
  logic [7:0]  pcl_value;
  logic [1:0]  page_sel;
  logic [10:0] fetch_addr;
  logic        flush;

  int n_checks;
  int n_fail;

  pcs_seq i_pcs_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_jump    (op_jump),
    .op_call    (op_call),
    .op_ret     (op_ret),
    .op_pcl_wr  (op_pcl_wr),
    .op_skip    (op_skip),
    .addr_field (addr_field),
    .pcl_value  (pcl_value),
    .page_sel   (page_sel),
    .fetch_addr (fetch_addr),
    .flush      (flush)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // {ret,call,jump,pcl,skip} tgt pcl page | expected addr, flush | requirement
  localparam int NV = 25;
  localparam logic [39:0] VEC [NV] = '{
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h1FF, 1'b0, 4'd1},  // R1 first cycle
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h200, 1'b0, 4'd2},  // R2 increment
    {5'b00100, 9'h0A5, 8'h00, 2'd1, 11'h201, 1'b1, 4'd3},  // R3 jump
    {5'b00100, 9'h000, 8'h00, 2'd0, 11'h2A5, 1'b0, 4'd9},  // R9 squashed jump
    {5'b01000, 9'h133, 8'h00, 2'd2, 11'h2A6, 1'b1, 4'd4},  // R4 call, bit 8 dropped
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h433, 1'b0, 4'd4},  // R4 call target
    {5'b01000, 9'h010, 8'h00, 2'd0, 11'h434, 1'b1, 4'd4},  // R4 nested call
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h010, 1'b0, 4'd4},
    {5'b01000, 9'h020, 8'h00, 2'd3, 11'h011, 1'b1, 4'd6},  // R6 third call
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h620, 1'b0, 4'd6},
    {5'b10000, 9'h000, 8'h00, 2'd0, 11'h621, 1'b1, 4'd5},  // R5 return
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h011, 1'b0, 4'd5},  // R5 newest entry
    {5'b10000, 9'h000, 8'h00, 2'd0, 11'h012, 1'b1, 4'd5},
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h434, 1'b0, 4'd5},  // R5 second entry
    {5'b10000, 9'h000, 8'h00, 2'd0, 11'h435, 1'b1, 4'd6},  // R6 return past depth
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h434, 1'b0, 4'd6},  // R6 deepest reused
    {5'b00010, 9'h000, 8'hC7, 2'd1, 11'h435, 1'b1, 4'd7},  // R7 computed jump
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h2C7, 1'b0, 4'd7},
    {5'b00001, 9'h000, 8'h00, 2'd0, 11'h2C8, 1'b1, 4'd8},  // R8 skip fires
    {5'b00001, 9'h000, 8'h00, 2'd0, 11'h2C9, 1'b0, 4'd9},  // R9 skipped skip
    {5'b00001, 9'h000, 8'h00, 2'd0, 11'h2CA, 1'b1, 4'd8},  // R8 live skip
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h2CB, 1'b0, 4'd8},
    {5'b00100, 9'h1FF, 8'h00, 2'd3, 11'h2CC, 1'b1, 4'd3},  // R3 jump to top
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h7FF, 1'b0, 4'd2},  // R2 wrap source
    {5'b00000, 9'h000, 8'h00, 2'd0, 11'h000, 1'b0, 4'd2}   // R2 wrapped
  };

  task automatic check(input int req, input string what,
                       input logic [10:0] act, input logic [10:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [8:0] t,
                       input logic [7:0] b, input logic [1:0] p);
    {op_ret, op_call, op_jump, op_pcl_wr, op_skip} = c;
    addr_field = t;
    pcl_value  = b;
    page_sel   = p;
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    drive(5'b0, 9'h0, 8'h0, 2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][39:35], VEC[i][34:26], VEC[i][25:18], VEC[i][17:16]);
      #1;
      check(int'(VEC[i][3:0]), $sformatf("row %0d addr", i), fetch_addr, VEC[i][15:5]);
      check(int'(VEC[i][3:0]), $sformatf("row %0d flush", i),
            {10'd0, flush}, {10'd0, VEC[i][4]});
    end

    // R1: reset in mid-run with a call strobe held
    @(negedge clk);
    drive(5'b01000, 9'h055, 8'h00, 2'd1);
    rst_n = 1'b0;
    #1;
    check(1, "reset addr", fetch_addr, 11'h1FF);
    check(1, "reset flush", {10'd0, flush}, 11'd0);
    @(negedge clk);
    drive(5'b0, 9'h0, 8'h0, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(1, "release addr", fetch_addr, 11'h1FF);
    @(negedge clk);
    #1;
    check(2, "first step after reset", fetch_addr, 11'h200);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule